// File: doc/BRIEF.md
# Asynchronous Memory Wait-State Controller

This block runs one bus cycle at a time against an asynchronous SRAM, ROM, flash device or I/O port. A requester presents an address, a direction flag, write data and the timing of the target area. The block then drives the chip select, the address-valid strobe, and either the read strobe or the write strobe, with a programmable gap before the strobe, a programmable strobe length, an optional stretch by an external ready line, a one-cycle hold and a programmable recovery gap. It ends the cycle by returning read data with a single-cycle done pulse.

The timing inputs are sampled when a request is accepted. The address decode that selects them and any bus-width adaptation stay outside the block. A request is only taken while the controller is idle. Requests raised during an access or its recovery are dropped.

Top module: `async_wait_ctrl`

## Requirements
- R1: After reset, and while idle, the chip select, address-valid, read strobe and write strobe outputs are high (inactive), `busy` is 0 and `rsp_done` is 0.
- R2: After a request is accepted, the chip select and address-valid outputs are low for exactly `cfg_setup` cycles before a strobe goes low. With `cfg_setup` = 0, the strobe is low in the first cycle after acceptance.
- R3: With ready extension disabled, the strobe is low for exactly `cfg_wait` + 1 consecutive cycles, for any `cfg_wait` from 0 to 15, and the level of `ext_rdy` has no effect on that length.
- R4: With ready extension enabled, `ext_rdy` passes through two flip-flops. The strobe is released only in a cycle where the synchronised ready is high and the programmed waits are used up. If `ext_rdy` rises during strobe cycle j (counted from 0) after being low, the strobe lasts max(`cfg_wait` + 1, j + 3) cycles.
- R5: A request with `req_write` = 0 drives only the read strobe. A request with `req_write` = 1 drives only the write strobe. The two strobes are never low together.
- R6: While the chip select is low, `mem_addr` equals the accepted address and stays stable. For writes, `mem_wdata` equals the accepted write data.
- R7: For reads, `rsp_rdata` holds the value present on `mem_rdata` during the last strobe cycle, and it is valid when `rsp_done` is high.
- R8: `rsp_done` is high for exactly one cycle per access. That cycle immediately follows the strobe release, with the chip select still low and both strobes high.
- R9: After the done cycle, the chip select is high and `busy` stays 1 for exactly `cfg_recover` cycles, and then the block is idle.
- R10: A request presented while `busy` is 1 is ignored. It starts no further access and does not change the address of the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_wait | input | WAIT_W | Automatic wait count (0 to 15) |
| cfg_rdy_en | input | 1 | Allow stretching by the external ready line |
| cfg_setup | input | SETUP_W | Cycles between select and strobe |
| cfg_recover | input | RECOV_W | Recovery cycles after the access |
| ext_rdy | input | 1 | Asynchronous ready from the device, high = ready |
| mem_rdata | input | DATA_W | Read data from the device |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Address to the device |
| mem_wdata | output | DATA_W | Write data to the device |
| busy | output | 1 | An access or its recovery is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
The assertions take `req_write` and the `cfg_*` inputs as meaningful only at acceptance, and they rely on the chip select being the only frame within which address stability is judged. The stimulus changes requests and timing only at the falling clock edge. It holds `ext_rdy` low for several cycles before any ready-stretched access, so the synchronised level is known when the strobe starts. It also raises junk requests only while `busy` is high, and withdraws them in the first idle cycle.

// File: rtl/awc_pkg.sv
// Package: shared state encoding for the asynchronous wait-state controller.
// Assumes: one access in flight at a time; states are decoded by the top module.
package awc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_RDYWAIT = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RECOVER = 3'd5
    } awc_state_e;

    // True in every state in which the device is selected.
    function automatic logic selected(input awc_state_e s);
        return (s == ST_SETUP) || (s == ST_STROBE) || (s == ST_RDYWAIT) || (s == ST_HOLD);
    endfunction

    // True in every state in which a strobe is driven.
    function automatic logic strobing(input awc_state_e s);
        return (s == ST_STROBE) || (s == ST_RDYWAIT);
    endfunction

endpackage

// File: rtl/awc_sync.sv
// Module: multi-stage synchroniser for a single asynchronous level.
// Assumes: input is a slow level (ready line); STAGES >= 2; output resets to RST_VAL.
module awc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: shift the level one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[i] <= RST_VAL;
                end else if (i == 0) begin
                    chain[i] <= async_in;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/awc_counter.sv
// Module: loadable down counter used for setup, wait and recovery phases.
// Assumes: load has priority over decrement; decrement at zero holds zero.
module awc_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt;

    // Purpose: hold the number of cycles still to run in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign is_zero = (cnt == '0);

endmodule

// File: rtl/awc_fsm.sv
// Module: phase sequencer IDLE -> SETUP -> STROBE -> RDYWAIT -> HOLD -> RECOVER -> IDLE.
// Assumes: the counter reports zero on the last cycle of each counted phase;
// live timing values are used at acceptance, held values afterwards.
module awc_fsm
    import awc_pkg::*;
#(
    parameter int WAIT_W  = 4,
    parameter int SETUP_W = 2,
    parameter int RECOV_W = 3,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SETUP_W-1:0] setup_live,
    input  logic [WAIT_W-1:0]  wait_live,
    input  logic [WAIT_W-1:0]  wait_held,
    input  logic [RECOV_W-1:0] recov_held,
    input  logic               rdy_en_held,
    input  logic               rdy_sync,
    input  logic               cnt_zero,
    output awc_state_e         state,
    output logic               accept,
    output logic               capture,
    output logic               cnt_load,
    output logic [CNT_W-1:0]   cnt_val,
    output logic               cnt_dec
);

    awc_state_e state_nx;

    // Purpose: choose the next phase and the counter action for it.
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        capture  = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    if (setup_live != '0) begin
                        state_nx = ST_SETUP;
                        cnt_val  = CNT_W'(setup_live - 1'b1);
                    end else begin
                        state_nx = ST_STROBE;
                        cnt_val  = CNT_W'(wait_live);
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_nx = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(wait_held);
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_STROBE: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (rdy_en_held && !rdy_sync) begin
                    state_nx = ST_RDYWAIT;
                end else begin
                    state_nx = ST_HOLD;
                    capture  = 1'b1;
                end
            end
            ST_RDYWAIT: begin
                if (rdy_sync) begin
                    state_nx = ST_HOLD;
                    capture  = 1'b1;
                end
            end
            ST_HOLD: begin
                if (recov_held != '0) begin
                    state_nx = ST_RECOVER;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(recov_held - 1'b1);
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) begin
                    state_nx = ST_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Purpose: hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/async_wait_ctrl.sv
// Module: top of the asynchronous memory wait-state controller.
// Holds the accepted request and timing, synchronises the ready line,
// captures read data and decodes the device strobes from the phase.
// Assumes: timing inputs are valid in the cycle req_valid is seen while idle.
module async_wait_ctrl
    import awc_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int WAIT_W      = 4,
    parameter int SETUP_W     = 2,
    parameter int RECOV_W     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic               cfg_rdy_en,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [RECOV_W-1:0] cfg_recover,
    input  logic               ext_rdy,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_cs_n,
    output logic               mem_adv_n,
    output logic               mem_rd_n,
    output logic               mem_wr_n,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               busy,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata
);

    localparam int CNT_A = (WAIT_W > SETUP_W) ? WAIT_W : SETUP_W;
    localparam int CNT_W = (CNT_A > RECOV_W) ? CNT_A : RECOV_W;

    awc_state_e         state;
    logic               accept;
    logic               capture;
    logic               cnt_load;
    logic [CNT_W-1:0]   cnt_val;
    logic               cnt_dec;
    logic               cnt_zero;
    logic               rdy_sync;

    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               write_q;
    logic [WAIT_W-1:0]  wait_q;
    logic               rdy_en_q;
    logic [RECOV_W-1:0] recov_q;
    logic [DATA_W-1:0]  rdata_q;

    awc_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_rdy),
        .sync_out (rdy_sync)
    );

    awc_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero)
    );

    awc_fsm #(
        .WAIT_W  (WAIT_W),
        .SETUP_W (SETUP_W),
        .RECOV_W (RECOV_W),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .setup_live  (cfg_setup),
        .wait_live   (cfg_wait),
        .wait_held   (wait_q),
        .recov_held  (recov_q),
        .rdy_en_held (rdy_en_q),
        .rdy_sync    (rdy_sync),
        .cnt_zero    (cnt_zero),
        .state       (state),
        .accept      (accept),
        .capture     (capture),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val),
        .cnt_dec     (cnt_dec)
    );

    // Purpose: hold the request and its timing for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            wait_q   <= '0;
            rdy_en_q <= 1'b0;
            recov_q  <= '0;
        end else if (accept) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            write_q  <= req_write;
            wait_q   <= cfg_wait;
            rdy_en_q <= cfg_rdy_en;
            recov_q  <= cfg_recover;
        end
    end

    // Purpose: take the device data on the last strobe cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture && !write_q) begin
            rdata_q <= mem_rdata;
        end
    end

    // Purpose: decode the device-side controls from the registered phase.
    always_comb begin
        mem_cs_n  = !selected(state);
        mem_adv_n = !selected(state);
        mem_rd_n  = !(strobing(state) && !write_q);
        mem_wr_n  = !(strobing(state) && write_q);
        busy      = (state != ST_IDLE);
        rsp_done  = (state == ST_HOLD);
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/awc_checker.sv
// Module: protocol checker for async_wait_ctrl, attached by bind.
// Assumes: observes ports only; reset is synchronous active-low.
module awc_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              mem_cs_n,
    input logic              mem_adv_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              rsp_done
);

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    a_r2_strobe_within_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> (!mem_cs_n && !mem_adv_n));

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!mem_cs_n && mem_rd_n && mem_wr_n && $past(!mem_rd_n || !mem_wr_n)));

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    a_r10_busy_ignores_request: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !rsp_done && !mem_cs_n) |=> $stable(mem_addr));

    a_r1_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && mem_rd_n && mem_wr_n && !rsp_done));

endmodule

bind async_wait_ctrl awc_checker #(
    .ADDR_W (ADDR_W)
) u_awc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_adv_n (mem_adv_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .rsp_done  (rsp_done)
);

// File: tb/test_async_wait_ctrl.sv
// Bench: directed corner cases plus seeded random accesses; expected phase
// lengths and read data are computed by bench functions from the requirements.
module test_async_wait_ctrl;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [3:0]        cfg_wait = '0;
    logic              cfg_rdy_en = 1'b0;
    logic [1:0]        cfg_setup = '0;
    logic [2:0]        cfg_recover = '0;
    logic              ext_rdy = 1'b1;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_cs_n, mem_adv_n, mem_rd_n, mem_wr_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              busy, rsp_done;
    logic [DATA_W-1:0] rsp_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    async_wait_ctrl i_async_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_wait(cfg_wait),
        .cfg_rdy_en(cfg_rdy_en), .cfg_setup(cfg_setup), .cfg_recover(cfg_recover),
        .ext_rdy(ext_rdy), .mem_rdata(mem_rdata), .mem_cs_n(mem_cs_n),
        .mem_adv_n(mem_adv_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Expected strobe length (R3, R4): j < 0 means ready is already high.
    function automatic int exp_strobe(input int w, input bit en, input int j);
        int len = w + 1;
        if (en && j >= 0 && j + 3 > len) len = j + 3;
        return len;
    endfunction

    function automatic int exp_rdata(input int token, input int last_idx);
        return (token ^ last_idx) & 16'hffff;
    endfunction

    // One access: drive at a falling edge, observe every later falling edge.
    task automatic run_access(input bit wr, input int addr, input int wdata,
                              input int w, input bit en, input int s, input int r,
                              input int j, input bit junk);
        int setup_c = 0, strb_c = 0, hold_c = 0, rec_c = 0, done_c = 0;
        int bad_type = 0, bad_addr = 0, bad_wdata = 0, bad_cs = 0;
        int done_data = -1;
        int token = (addr * 7 + 16'h3a5) & 16'hffff;
        int guard = 0;
        if (j >= 0) begin
            ext_rdy = 1'b0;
            repeat (3) @(negedge clk);
        end
        req_valid   = 1'b1;
        req_write   = wr;
        req_addr    = ADDR_W'(addr);
        req_wdata   = DATA_W'(wdata);
        cfg_wait    = 4'(w);
        cfg_rdy_en  = en;
        cfg_setup   = 2'(s);
        cfg_recover = 3'(r);
        mem_rdata   = ~DATA_W'(token);
        forever begin
            @(negedge clk);
            guard++;
            if (junk) begin
                req_addr  = ADDR_W'(addr ^ 24'h5a5a5a);
                req_write = ~wr;
                cfg_wait  = 4'(w ^ 5);
            end else begin
                req_valid = 1'b0;
            end
            mem_rdata = ~DATA_W'(token);
            if (!mem_cs_n) begin
                if (mem_addr != ADDR_W'(addr)) bad_addr++;
                if (mem_adv_n) bad_addr++;
                if (wr && mem_wdata != DATA_W'(wdata)) bad_wdata++;
                if (!mem_rd_n || !mem_wr_n) begin
                    if (wr ? (mem_wr_n || !mem_rd_n) : (mem_rd_n || !mem_wr_n)) bad_type++;
                    mem_rdata = DATA_W'(exp_rdata(token, strb_c));
                    if (j >= 0 && strb_c == j) ext_rdy = 1'b1;
                    strb_c++;
                end else if (strb_c == 0) setup_c++;
                else hold_c++;
            end else if (busy) rec_c++;
            if (rsp_done) begin
                done_c++;
                done_data = int'(rsp_rdata);
                if (mem_cs_n) bad_cs++;
            end
            if (!busy || guard > 200) break;
        end
        req_valid = 1'b0;
        ext_rdy   = 1'b1;
        check("R2 setup cycles", setup_c, s);
        if (en) check("R4 strobe cycles", strb_c, exp_strobe(w, en, j));
        else    check("R3 strobe cycles", strb_c, exp_strobe(w, en, j));
        check("R5 strobe matches direction", bad_type, 0);
        check("R6 address held", bad_addr, 0);
        check("R6 write data held", bad_wdata, 0);
        check("R8 done count", done_c, 1);
        check("R8 done inside select", bad_cs, 0);
        check("R8 hold cycles", hold_c, 1);
        check("R9 recovery cycles", rec_c, r);
        if (!wr) check("R7 read data", done_data, exp_rdata(token, exp_strobe(w, en, j) - 1));
        @(negedge clk);
        check("R10 idle after access", int'(busy), 0);
        check("R1 idle outputs", int'({mem_cs_n, mem_rd_n, mem_wr_n, rsp_done}), 4'b1110);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        repeat (3) @(negedge clk);
        check("R1 reset cs_n", int'(mem_cs_n), 1);
        check("R1 reset strobes", int'({mem_rd_n, mem_wr_n, mem_adv_n}), 3'b111);
        check("R1 reset busy/done", int'({busy, rsp_done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Directed corners.
        run_access(1'b0, 24'h000100, 0, 0, 1'b0, 0, 0, -1, 1'b0);  // shortest read
        run_access(1'b1, 24'hfffffe, 16'hbeef, 15, 1'b0, 3, 7, -1, 1'b0); // longest fixed write
        run_access(1'b0, 24'h123456, 0, 2, 1'b0, 1, 1, 10, 1'b0);  // R3: ready low ignored
        run_access(1'b0, 24'h0abcde, 0, 1, 1'b1, 0, 2, 20, 1'b0);  // R4: long stretch
        run_access(1'b1, 24'h0a0a0a, 16'h1234, 6, 1'b1, 2, 0, 3, 1'b0); // R4: waits dominate
        run_access(1'b0, 24'h00beef, 0, 3, 1'b1, 1, 3, -1, 1'b0);  // R4: ready already high
        run_access(1'b0, 24'h777777, 0, 4, 1'b0, 2, 4, -1, 1'b1);  // R10: junk during busy
        // Random accesses.
        for (int k = 0; k < 40; k++) begin
            int j = int'($urandom_range(0, 12)) - 2;
            run_access(1'($urandom_range(0, 1)), int'($urandom & 24'hffffff),
                       int'($urandom & 16'hffff), int'($urandom_range(0, 15)),
                       1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 7)), (j < 0) ? -1 : j,
                       1'($urandom_range(0, 1)));
        end
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule